// File: doc/BRIEF.md
# Indirect Data Address Generator

This block computes the data-space address for every load and store issued by a small 8-bit core. Three 16-bit pointers (X, Y and Z) live as pairs of 8-bit registers in the register file. Their current values arrive on dedicated inputs. The block does four things with a request:

- It applies the selected addressing mode.
- It returns the effective address.
- It classifies the address as register file, I/O, SRAM or out of range.
- For the modes that update a pointer, it returns the new pointer value and the register-file index of its low byte. Both bytes can then be written back in the same cycle.

The result is registered, so a request presented in one cycle yields its answer after the next clock edge. That edge forms the address phase of the core's two-cycle memory access. Direct addressing takes a full 16-bit address from the instruction and ignores the pointers.

The Z pointer is also driven, without a register, onto a separate output. The program-memory side uses it for constant-table lookup and for indirect jumps and calls.

Top module: `data_addr_gen`

## Requirements
- R1: While reset is asserted and after its release with no request, `res_valid`, `res_err` and `wb_en` are 0.
- R2: A request sampled with `req_valid`=1 on a rising edge produces `res_valid`=1 right after that edge. An edge with `req_valid`=0 produces `res_valid`=0.
- R3: Mode code 0 (plain) yields the selected pointer as the address, with `wb_en`=0.
- R4: Mode code 1 (post-increment) yields the old pointer as the address. It also yields `wb_en`=1 and `wb_value` = pointer+1 modulo 2^16.
- R5: Mode code 2 (pre-decrement) yields pointer−1 modulo 2^16 both as the address and as `wb_value`, with `wb_en`=1.
- R6: Mode code 3 (displacement) on Y or Z yields pointer + `req_disp`, where `req_disp` is an unsigned 0..63 value. It gives `wb_en`=0.
- R7: Several requests are illegal: displacement on X, a pointer mode with pointer code 3, and mode codes 5..7. Each gives `res_err`=1, `wb_en`=0 and region code 3.
- R8: Mode code 4 (direct) yields `req_direct` as the address, whatever the pointer code and pointer values. It gives `wb_en`=0 and `res_err`=0.
- R9: The region code follows the address. Code 0 covers 0x00..0x1F (register file) and code 1 covers 0x20..0x5F (I/O). Code 2 covers 0x60..0xDF (SRAM), and code 3 covers everything above 0xDF.
- R10: Pointer codes are X=0, Y=1 and Z=2. With `wb_en`=1, `wb_idx` is the even low-byte register: 26 for X, 28 for Y and 30 for Z.
- R11: `prog_addr` equals `ptr_z` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ptr | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| req_mode | input | 3 | Mode: 0 plain, 1 post-inc, 2 pre-dec, 3 displacement, 4 direct |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Direct address from the instruction |
| ptr_x | input | 16 | Current X pointer (R27:R26) |
| ptr_y | input | 16 | Current Y pointer (R29:R28) |
| ptr_z | input | 16 | Current Z pointer (R31:R30) |
| res_valid | output | 1 | Result valid |
| res_addr | output | 16 | Effective data address |
| res_region | output | 2 | 0 register file, 1 I/O, 2 SRAM, 3 out of range |
| res_err | output | 1 | Illegal request |
| wb_en | output | 1 | Pointer write-back enable |
| wb_idx | output | 5 | Register index of the pointer's low byte |
| wb_value | output | 16 | Updated 16-bit pointer value |
| prog_addr | output | 16 | Z pointer for program-memory access |

## Verification
The bench probes every region edge from both sides: 0x1F/0x20, 0x5F/0x60 and 0xDF/0xE0. A decoder with an off-by-one limit would misfile one of these addresses.

The pointer arithmetic is tested at its wrap points:
- Post-increment from 0xFFFF must write back 0x0000 while still addressing 0xFFFF. A design that used the incremented value as the address would report the wrong region here.
- Pre-decrement from 0x0000 must address 0xFFFF. A design that updated the pointer after the access would still address 0x0000.

A maximum displacement of 63 is applied to Y and to Z, and the same mode is attempted on X. A design that accepted the X case would assert write-back or drop the error. Direct requests carry pointer code 3, which must not raise an error.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [1:0] {
      PTR_X    = 2'd0,
      PTR_Y    = 2'd1,
      PTR_Z    = 2'd2,
      PTR_NONE = 2'd3
   } ptr_sel_e;

   typedef enum logic [2:0] {
      AM_PLAIN   = 3'd0,
      AM_POSTINC = 3'd1,
      AM_PREDEC  = 3'd2,
      AM_DISP    = 3'd3,
      AM_DIRECT  = 3'd4
   } amode_e;

   typedef enum logic [1:0] {
      RGN_REGF = 2'd0,
      RGN_IO   = 2'd1,
      RGN_SRAM = 2'd2,
      RGN_OOR  = 2'd3
   } region_e;

   localparam int NUM_PTRS = 3;
endpackage

// File: rtl/dag_ptr_sel.sv
module dag_ptr_sel
   import dag_pkg::*;
#(
   parameter int AW      = 16,
   parameter int IDXW    = 5,
   parameter int LO_BASE = 26
) (
   input  logic [1:0]      sel,
   input  logic [AW-1:0]   px,
   input  logic [AW-1:0]   py,
   input  logic [AW-1:0]   pz,
   output logic [AW-1:0]   val,
   output logic [IDXW-1:0] lo_idx,
   output logic            known
);
   logic [AW-1:0]   bank   [NUM_PTRS];
   logic [IDXW-1:0] idxtbl [NUM_PTRS];

   assign bank[0] = px;
   assign bank[1] = py;
   assign bank[2] = pz;

   for (genvar g = 0; g < NUM_PTRS; g++) begin : g_idx
      assign idxtbl[g] = IDXW'(LO_BASE + 2 * g);
   end

   always_comb begin
      known  = (sel != PTR_NONE);
      val    = '0;
      lo_idx = '0;
      if (known) begin
         val    = bank[sel];
         lo_idx = idxtbl[sel];
      end
   end
endmodule

// File: rtl/dag_ea_calc.sv
module dag_ea_calc
   import dag_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 6,
   parameter bit ALLOW_X_DISP = 1'b0
) (
   input  logic [2:0]    mode,
   input  logic [1:0]    sel,
   input  logic          known,
   input  logic [AW-1:0] pval,
   input  logic [DW-1:0] disp,
   input  logic [AW-1:0] direct,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] nxt,
   output logic          wb,
   output logic          bad
);
   logic disp_ok;

   if (ALLOW_X_DISP) begin : g_disp_all
      assign disp_ok = known;
   end else begin : g_disp_yz
      assign disp_ok = (sel == PTR_Y) || (sel == PTR_Z);
   end

   logic [AW-1:0] inc_v, dec_v, off_v;
   assign inc_v = pval + AW'(1);
   assign dec_v = pval - AW'(1);
   assign off_v = pval + AW'(disp);

   always_comb begin
      ea  = '0;
      nxt = pval;
      wb  = 1'b0;
      bad = 1'b0;
      case (mode)
         AM_PLAIN: begin
            ea  = pval;
            bad = !known;
         end
         AM_POSTINC: begin
            ea  = pval;
            nxt = inc_v;
            wb  = known;
            bad = !known;
         end
         AM_PREDEC: begin
            ea  = dec_v;
            nxt = dec_v;
            wb  = known;
            bad = !known;
         end
         AM_DISP: begin
            ea  = off_v;
            bad = !disp_ok;
         end
         AM_DIRECT: begin
            ea = direct;
         end
         default: bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/dag_region_dec.sv
module dag_region_dec
   import dag_pkg::*;
#(
   parameter int AW        = 16,
   parameter int REGF_SIZE = 32,
   parameter int IO_SIZE   = 64,
   parameter int SRAM_SIZE = 128
) (
   input  logic [AW-1:0] addr,
   output logic [1:0]    region
);
   localparam int IO_BASE   = REGF_SIZE;
   localparam int SRAM_BASE = IO_BASE + IO_SIZE;
   localparam int SRAM_TOP  = SRAM_BASE + SRAM_SIZE;

   if (SRAM_TOP > (1 << AW)) begin : g_chk_span
      $error("memory regions exceed the address width");
   end

   always_comb begin
      if (addr < AW'(IO_BASE))        region = RGN_REGF;
      else if (addr < AW'(SRAM_BASE)) region = RGN_IO;
      else if (addr < AW'(SRAM_TOP))  region = RGN_SRAM;
      else                            region = RGN_OOR;
   end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
   import dag_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 6,
   parameter int REGF_SIZE    = 32,
   parameter int IO_SIZE      = 64,
   parameter int SRAM_SIZE    = 128,
   parameter bit ALLOW_X_DISP = 1'b0,
   localparam int IDXW        = $clog2(REGF_SIZE),
   localparam int LO_BASE     = REGF_SIZE - 2 * NUM_PTRS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [1:0]      req_ptr,
   input  logic [2:0]      req_mode,
   input  logic [DW-1:0]   req_disp,
   input  logic [AW-1:0]   req_direct,
   input  logic [AW-1:0]   ptr_x,
   input  logic [AW-1:0]   ptr_y,
   input  logic [AW-1:0]   ptr_z,
   output logic            res_valid,
   output logic [AW-1:0]   res_addr,
   output logic [1:0]      res_region,
   output logic            res_err,
   output logic            wb_en,
   output logic [IDXW-1:0] wb_idx,
   output logic [AW-1:0]   wb_value,
   output logic [AW-1:0]   prog_addr
);
   if (AW < 8) begin : g_chk_aw
      $error("address width too small");
   end
   if (REGF_SIZE < 2 * NUM_PTRS || (REGF_SIZE % 2) != 0) begin : g_chk_rf
      $error("register file must be even and hold all pointer pairs");
   end
   if (DW < 1 || DW >= AW) begin : g_chk_dw
      $error("displacement width out of range");
   end

   logic [AW-1:0]   sel_val;
   logic [IDXW-1:0] sel_idx;
   logic            sel_known;
   logic [AW-1:0]   ea, nxt;
   logic            upd, bad;
   logic [1:0]      rgn;

   dag_ptr_sel #(.AW(AW), .IDXW(IDXW), .LO_BASE(LO_BASE)) u_sel (
      .sel(req_ptr), .px(ptr_x), .py(ptr_y), .pz(ptr_z),
      .val(sel_val), .lo_idx(sel_idx), .known(sel_known)
   );

   dag_ea_calc #(.AW(AW), .DW(DW), .ALLOW_X_DISP(ALLOW_X_DISP)) u_calc (
      .mode(req_mode), .sel(req_ptr), .known(sel_known), .pval(sel_val),
      .disp(req_disp), .direct(req_direct),
      .ea(ea), .nxt(nxt), .wb(upd), .bad(bad)
   );

   dag_region_dec #(.AW(AW), .REGF_SIZE(REGF_SIZE), .IO_SIZE(IO_SIZE),
                    .SRAM_SIZE(SRAM_SIZE)) u_rgn (
      .addr(ea), .region(rgn)
   );

   assign prog_addr = ptr_z;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_addr   <= '0;
         res_region <= RGN_REGF;
         res_err    <= 1'b0;
         wb_en      <= 1'b0;
         wb_idx     <= '0;
         wb_value   <= '0;
      end else begin
         res_valid <= req_valid;
         if (req_valid) begin
            res_addr   <= bad ? '0 : ea;
            res_region <= bad ? RGN_OOR : rgn;
            res_err    <= bad;
            wb_en      <= upd && !bad;
            wb_idx     <= sel_idx;
            wb_value   <= nxt;
         end else begin
            res_err <= 1'b0;
            wb_en   <= 1'b0;
         end
      end
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> res_valid); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !res_valid && !wb_en); // R2
   AST_ERR_NO_WB: assert property (@(posedge clk) disable iff (!rst_n) res_err |-> !wb_en && res_region == RGN_OOR); // R7
   AST_WB_STEP: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> (wb_value == res_addr + AW'(1)) || (wb_value == res_addr)); // R4
   AST_WB_IDX_EVEN: assert property (@(posedge clk) disable iff (!rst_n) wb_en |-> !wb_idx[0]); // R10
   AST_REGF_LOW: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_err && res_addr < AW'(REGF_SIZE)) |-> res_region == RGN_REGF); // R9
   AST_DIRECT_OK: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_mode == AM_DIRECT) |=> !res_err && !wb_en); // R8

   if (!ALLOW_X_DISP) begin : g_ast_xdisp
      AST_X_DISP_ERR: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ptr == PTR_X && req_mode == AM_DISP) |=> res_err); // R7
   end
endmodule

// File: tb/tb_data_addr_gen.sv
module tb_data_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_ptr = '0;
   logic [2:0]  req_mode = '0;
   logic [5:0]  req_disp = '0;
   logic [15:0] req_direct = '0;
   logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
   logic        res_valid, res_err, wb_en;
   logic [15:0] res_addr, wb_value, prog_addr;
   logic [1:0]  res_region;
   logic [4:0]  wb_idx;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   data_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
      .req_mode(req_mode), .req_disp(req_disp), .req_direct(req_direct),
      .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
      .res_valid(res_valid), .res_addr(res_addr), .res_region(res_region),
      .res_err(res_err), .wb_en(wb_en), .wb_idx(wb_idx), .wb_value(wb_value),
      .prog_addr(prog_addr)
   );

   typedef struct {
      string       tag;
      logic [15:0] addr;
      logic [1:0]  region;
      logic        err;
      logic        wb;
      logic [4:0]  idx;
      logic [15:0] val;
   } exp_t;

   exp_t sb[$];

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [1:0] rgn_of(input logic [15:0] a);
      if (a < 16'h20) return 2'd0;
      if (a < 16'h60) return 2'd1;
      if (a < 16'hE0) return 2'd2;
      return 2'd3;
   endfunction

   task automatic send(input string tag, input logic [1:0] p, input logic [2:0] m,
                       input logic [5:0] q, input logic [15:0] d);
      exp_t e;
      logic [15:0] pv;
      @(negedge clk);
      req_valid = 1'b1; req_ptr = p; req_mode = m; req_disp = q; req_direct = d;
      pv = (p == 2'd0) ? ptr_x : (p == 2'd1) ? ptr_y : ptr_z;
      e.tag = tag; e.err = 1'b0; e.wb = 1'b0; e.val = 16'h0; e.addr = 16'h0;
      e.idx = 5'(26 + 2 * p);
      case (m)
         3'd0: begin e.addr = pv; e.err = (p == 2'd3); end
         3'd1: begin e.addr = pv; e.wb = 1'b1; e.val = pv + 16'd1; e.err = (p == 2'd3); end
         3'd2: begin e.addr = pv - 16'd1; e.wb = 1'b1; e.val = pv - 16'd1; e.err = (p == 2'd3); end
         3'd3: begin e.addr = pv + {10'd0, q}; e.err = !(p == 2'd1 || p == 2'd2); end
         3'd4: e.addr = d;
         default: e.err = 1'b1;
      endcase
      if (e.err) e.wb = 1'b0;
      e.region = e.err ? 2'd3 : rgn_of(e.addr);
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: pops the expected item whenever a result is presented.
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R2", "unexpected result", 16'(res_valid), 16'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(res_err == e.err, e.tag, "err", 16'(res_err), 16'(e.err));
            chk(res_region == e.region, e.tag, "region", 16'(res_region), 16'(e.region));
            chk(wb_en == e.wb, e.tag, "wb_en", 16'(wb_en), 16'(e.wb));
            if (!e.err) chk(res_addr == e.addr, e.tag, "addr", res_addr, e.addr);
            if (e.wb) begin
               chk(wb_value == e.val, e.tag, "wb_value", wb_value, e.val);
               chk(wb_idx == e.idx, "R10", "wb_idx", 16'(wb_idx), 16'(e.idx));
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!res_valid && !res_err && !wb_en, "R1", "outputs in reset",
          {13'd0, res_valid, res_err, wb_en}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!res_valid && !wb_en, "R1", "outputs after reset",
          {14'd0, res_valid, wb_en}, 16'h0);

      // R11: Z passes straight through to the program side
      ptr_z = 16'h3A5C; #1;
      chk(prog_addr == 16'h3A5C, "R11", "prog_addr", prog_addr, 16'h3A5C);

      // R3 / R9 plain accesses on region edges
      ptr_x = 16'h001F; ptr_y = 16'h0020; ptr_z = 16'h005F;
      send("R3", 2'd0, 3'd0, 6'd0, 16'h0);
      send("R9", 2'd1, 3'd0, 6'd0, 16'h0);
      send("R9", 2'd2, 3'd0, 6'd0, 16'h0);
      idle();
      @(negedge clk);
      chk(!res_valid && !wb_en, "R2", "idle cycle", {14'd0, res_valid, wb_en}, 16'h0);

      // R4 post-increment, including wrap
      ptr_x = 16'h005F; ptr_z = 16'hFFFF;
      send("R4", 2'd0, 3'd1, 6'd0, 16'h0);
      send("R4", 2'd2, 3'd1, 6'd0, 16'h0);
      // R5 pre-decrement, including wrap
      ptr_y = 16'h0060; ptr_x = 16'h0000;
      send("R5", 2'd1, 3'd2, 6'd0, 16'h0);
      send("R5", 2'd0, 3'd2, 6'd0, 16'h0);
      // R6 displacement on Y and Z at the SRAM top edge
      ptr_y = 16'h0050; ptr_z = 16'h00A0;
      send("R6", 2'd1, 3'd3, 6'd63, 16'h0);
      send("R6", 2'd2, 3'd3, 6'd63, 16'h0);
      send("R6", 2'd1, 3'd3, 6'd0, 16'h0);
      ptr_z = 16'h00A1;
      send("R9", 2'd2, 3'd3, 6'd63, 16'h0);
      // R7 illegal requests
      send("R7", 2'd0, 3'd3, 6'd5, 16'h0);
      send("R7", 2'd3, 3'd0, 6'd0, 16'h0);
      send("R7", 2'd3, 3'd1, 6'd0, 16'h0);
      send("R7", 2'd1, 3'd5, 6'd0, 16'h0);
      send("R7", 2'd2, 3'd7, 6'd0, 16'h0);
      // R8 direct, pointer field ignored
      send("R8", 2'd3, 3'd4, 6'd9, 16'h00E0);
      send("R8", 2'd0, 3'd4, 6'd0, 16'h0060);
      send("R8", 2'd2, 3'd4, 6'd0, 16'h00DF);
      idle();
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R2", "results outstanding", 16'(sb.size()), 16'h0);
      finish_run();
   end
endmodule